// File: doc/BRIEF.md
# Mirrored SRAM controller with per-word checksum

This controller sits between a processor-side request port and two identical external synchronous SRAM chips. Each chip stores 36-bit words: 32 data bits and a 4-bit checksum that the controller computes on every write. Every access goes to both chips in the same cycle, so each location is held twice.

On a read, the controller compares the two returned words. If they agree, the data is returned with no extra cost. If they differ, the checksum of each copy picks out the damaged chip. The controller returns the intact copy and, in the next memory cycle, writes that copy over the damaged location while the request port is held off. A disagreement that the checksums cannot settle is reported as uncorrectable. Saturating counters of corrected and uncorrectable events, a per-chip blame pulse and a per-chip sticky fault bit give software a view of the health of the chips.

The SRAM chips register the address on a clock edge and return the read word in the following cycle. A read response therefore appears in the cycle after the request is accepted.

Top module: `mirror_mem_ctrl`

## Requirements
- R1: An accepted request (`reqValid` and `reqReady` high) enables both chips in the same cycle, with the same address, the same write enable and, for writes, the same 36-bit word.
- R2: A written word is laid out as checksum in bits 35:32 and data in bits 31:0. The checksum is a CRC over the 32 data bits, most significant bit first, with generator x^4+x+1 and an all-zero start value.
- R3: A read accepted in cycle n gives `rspValid` high in cycle n+1. When both copies are identical, `rspData` is their data, `reqReady` stays high and no counter changes.
- R4: When the copies differ and exactly one copy's checksum is wrong, `rspData` carries the other copy's data. In the same cycle, `chipFail` pulses the bit of the blamed chip (bit 0 for chip A, bit 1 for chip B), and the corrected count rises by one.
- R5: In the response cycle of a corrected read, only the blamed chip is enabled. It is written, at the read address, with the full 36-bit word of its partner, and `reqReady` is low for exactly that one cycle.
- R6: When the copies differ and both checksums are right, or both are wrong, `rspErr` is high, `rspData` carries chip A's data, the uncorrectable count rises by one, `chipFail` stays zero, nothing is written back and `reqReady` stays high.
- R7: Each count holds at its maximum value, 2^CNT_W-1, instead of wrapping.
- R8: `cntClear` high at a clock edge zeroes both counts and both sticky fault bits, and it overrides any increment or set at the same edge.
- R9: A sticky fault bit is set by a correction that blames its chip and stays set until it is cleared.
- R10: After reset, both counts and both fault bits are zero, `rspValid` is low and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqReady | output | 1 | Request accepted this cycle when high |
| rspValid | output | 1 | Read response present |
| rspData | output | DATA_W | Read data |
| rspErr | output | 1 | Response could not be corrected |
| memAEn | output | 1 | Chip A enable |
| memAWe | output | 1 | Chip A write enable |
| memAAddr | output | ADDR_W | Chip A address |
| memAWdata | output | DATA_W+4 | Chip A write word |
| memARdata | input | DATA_W+4 | Chip A read word, one cycle after enable |
| memBEn | output | 1 | Chip B enable |
| memBWe | output | 1 | Chip B write enable |
| memBAddr | output | ADDR_W | Chip B address |
| memBWdata | output | DATA_W+4 | Chip B write word |
| memBRdata | input | DATA_W+4 | Chip B read word, one cycle after enable |
| chipFail | output | 2 | Blame pulse per chip (bit 0 A, bit 1 B) |
| faultLatched | output | 2 | Sticky per-chip fault bits |
| corrCount | output | CNT_W | Corrected-read count |
| uncorrCount | output | CNT_W | Uncorrectable-read count |
| cntClear | input | 1 | Synchronous clear of counts and fault bits |

## Verification
The bench builds the controller with ADDR_W=4 and CNT_W=3 and keeps DATA_W at 32. With 16 locations, the bench's own SRAM models are small enough to flip bits directly. With 3-bit counts, both counters reach their ceiling of 7 after a handful of injected faults, so the hold at the top and the clear that overrides an increment can both be observed. The full 32-bit data path keeps the checksum arithmetic the same as in the default build.

// File: rtl/mirror_mem_pkg.sv
package mirror_mem_pkg;

  localparam int CHK_W = 4;
  localparam logic [CHK_W-1:0] CHK_POLY = 4'h3;  // x^4 + x + 1

  // Outcome of comparing the two returned copies
  typedef enum logic [1:0] {
    VERDICT_CLEAN = 2'd0,  // copies identical
    VERDICT_FIX_A = 2'd1,  // chip A damaged, B intact
    VERDICT_FIX_B = 2'd2,  // chip B damaged, A intact
    VERDICT_LOST  = 2'd3   // cannot tell which copy is right
  } verdict_e;

  // Control -> datapath strobes
  typedef struct packed {
    logic issue;
    logic issueWrite;
    logic repairA;
    logic repairB;
    logic bumpCorr;
    logic bumpLost;
    logic clear;
  } strobe_t;

endpackage

// File: rtl/mirror_mem_dp.sv
module mirror_mem_dp
  import mirror_mem_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [DATA_W-1:0]       reqWdata,
  input  logic [DATA_W+CHK_W-1:0] memARdata,
  input  logic [DATA_W+CHK_W-1:0] memBRdata,
  output logic                    memAEn,
  output logic                    memAWe,
  output logic [ADDR_W-1:0]       memAAddr,
  output logic [DATA_W+CHK_W-1:0] memAWdata,
  output logic                    memBEn,
  output logic                    memBWe,
  output logic [ADDR_W-1:0]       memBAddr,
  output logic [DATA_W+CHK_W-1:0] memBWdata,
  output verdict_e                verdict,
  output logic [DATA_W-1:0]       rspData,
  output logic [CNT_W-1:0]        corrCount,
  output logic [CNT_W-1:0]        uncorrCount,
  output logic [1:0]              faultLatched
);

  localparam int WORD_W = DATA_W + CHK_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CHK_W-1:0] calcChk(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] r;
    logic fb;
    r = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = r[CHK_W-1] ^ d[i];
      r  = {r[CHK_W-2:0], 1'b0} ^ (fb ? CHK_POLY : '0);
    end
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] cur, input logic inc);
    return (inc && cur != CNT_MAX) ? cur + 1'b1 : cur;
  endfunction

  logic [WORD_W-1:0] rdWord [2];
  logic [1:0]        chkOk;
  logic [1:0]        repair;
  logic [1:0]        chipEn;
  logic [1:0]        chipWe;
  logic [ADDR_W-1:0] chipAddr [2];
  logic [WORD_W-1:0] chipWdata [2];
  logic [ADDR_W-1:0] pendAddr;
  logic [WORD_W-1:0] goodWord;
  logic [WORD_W-1:0] issueWord;

  assign rdWord[0] = memARdata;
  assign rdWord[1] = memBRdata;
  assign repair    = {strobe.repairB, strobe.repairA};
  assign issueWord = {calcChk(reqWdata), reqWdata};

  for (genvar c = 0; c < 2; c++) begin : g_chip
    assign chkOk[c]     = (calcChk(rdWord[c][DATA_W-1:0]) == rdWord[c][WORD_W-1:DATA_W]);
    assign chipEn[c]    = strobe.issue | repair[c];
    assign chipWe[c]    = (strobe.issue & strobe.issueWrite) | repair[c];
    assign chipAddr[c]  = repair[c] ? pendAddr : reqAddr;
    assign chipWdata[c] = repair[c] ? goodWord : issueWord;
  end

  assign memAEn    = chipEn[0];
  assign memAWe    = chipWe[0];
  assign memAAddr  = chipAddr[0];
  assign memAWdata = chipWdata[0];
  assign memBEn    = chipEn[1];
  assign memBWe    = chipWe[1];
  assign memBAddr  = chipAddr[1];
  assign memBWdata = chipWdata[1];

  always_comb begin
    if (memARdata == memBRdata) verdict = VERDICT_CLEAN;
    else if (chkOk == 2'b10)    verdict = VERDICT_FIX_A;
    else if (chkOk == 2'b01)    verdict = VERDICT_FIX_B;
    else                        verdict = VERDICT_LOST;
  end

  assign goodWord = (verdict == VERDICT_FIX_A) ? memBRdata : memARdata;
  assign rspData  = goodWord[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pendAddr <= '0;
    else if (strobe.issue) pendAddr <= reqAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      corrCount    <= '0;
      uncorrCount  <= '0;
      faultLatched <= '0;
    end else if (strobe.clear) begin
      corrCount    <= '0;
      uncorrCount  <= '0;
      faultLatched <= '0;
    end else begin
      corrCount    <= bump(corrCount, strobe.bumpCorr);
      uncorrCount  <= bump(uncorrCount, strobe.bumpLost);
      faultLatched <= faultLatched | repair;
    end
  end

endmodule

// File: rtl/mirror_mem_ctl.sv
module mirror_mem_ctl
  import mirror_mem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       cntClear,
  input  verdict_e   verdict,
  output logic       reqReady,
  output logic       rspValid,
  output logic       rspErr,
  output logic [1:0] chipFail,
  output strobe_t    strobe
);

  logic pendRead;
  logic fixA;
  logic fixB;
  logic lost;

  assign fixA     = pendRead && (verdict == VERDICT_FIX_A);
  assign fixB     = pendRead && (verdict == VERDICT_FIX_B);
  assign lost     = pendRead && (verdict == VERDICT_LOST);
  assign reqReady = !(fixA || fixB);
  assign rspValid = pendRead;
  assign rspErr   = lost;
  assign chipFail = {fixB, fixA};

  always_comb begin
    strobe.issue      = reqValid && reqReady;
    strobe.issueWrite = reqWrite;
    strobe.repairA    = fixA;
    strobe.repairB    = fixB;
    strobe.bumpCorr   = fixA || fixB;
    strobe.bumpLost   = lost;
    strobe.clear      = cntClear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendRead <= 1'b0;
    else       pendRead <= strobe.issue && !reqWrite;
  end

endmodule

// File: rtl/mirror_mem_ctrl.sv
module mirror_mem_ctrl
  import mirror_mem_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [DATA_W-1:0]       reqWdata,
  output logic                    reqReady,
  output logic                    rspValid,
  output logic [DATA_W-1:0]       rspData,
  output logic                    rspErr,
  output logic                    memAEn,
  output logic                    memAWe,
  output logic [ADDR_W-1:0]       memAAddr,
  output logic [DATA_W+CHK_W-1:0] memAWdata,
  input  logic [DATA_W+CHK_W-1:0] memARdata,
  output logic                    memBEn,
  output logic                    memBWe,
  output logic [ADDR_W-1:0]       memBAddr,
  output logic [DATA_W+CHK_W-1:0] memBWdata,
  input  logic [DATA_W+CHK_W-1:0] memBRdata,
  output logic [1:0]              chipFail,
  output logic [1:0]              faultLatched,
  output logic [CNT_W-1:0]        corrCount,
  output logic [CNT_W-1:0]        uncorrCount,
  input  logic                    cntClear
);

  strobe_t  strobe;
  verdict_e verdict;

  mirror_mem_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .cntClear (cntClear),
    .verdict  (verdict),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .rspErr   (rspErr),
    .chipFail (chipFail),
    .strobe   (strobe)
  );

  mirror_mem_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqAddr      (reqAddr),
    .reqWdata     (reqWdata),
    .memARdata    (memARdata),
    .memBRdata    (memBRdata),
    .memAEn       (memAEn),
    .memAWe       (memAWe),
    .memAAddr     (memAAddr),
    .memAWdata    (memAWdata),
    .memBEn       (memBEn),
    .memBWe       (memBWe),
    .memBAddr     (memBAddr),
    .memBWdata    (memBWdata),
    .verdict      (verdict),
    .rspData      (rspData),
    .corrCount    (corrCount),
    .uncorrCount  (uncorrCount),
    .faultLatched (faultLatched)
  );

endmodule

// File: rtl/mirror_mem_checker.sv
module mirror_mem_checker
  import mirror_mem_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    reqValid,
  input logic                    reqWrite,
  input logic                    reqReady,
  input logic                    rspValid,
  input logic                    rspErr,
  input logic [1:0]              chipFail,
  input logic                    memAEn,
  input logic                    memAWe,
  input logic [ADDR_W-1:0]       memAAddr,
  input logic [DATA_W+CHK_W-1:0] memAWdata,
  input logic [DATA_W+CHK_W-1:0] memARdata,
  input logic                    memBEn,
  input logic                    memBWe,
  input logic [ADDR_W-1:0]       memBAddr,
  input logic [DATA_W+CHK_W-1:0] memBWdata,
  input logic [DATA_W+CHK_W-1:0] memBRdata,
  input logic [1:0]              faultLatched,
  input logic [CNT_W-1:0]        corrCount,
  input logic [CNT_W-1:0]        uncorrCount,
  input logic                    cntClear
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  assert_mirror_issue_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |-> (memAEn && memBEn && memAAddr == memBAddr &&
                                memAWe == memBWe && (!reqWrite || memAWdata == memBWdata)));

  assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite) |=> rspValid);

  assert_repair_chip_a_R5: assert property (@(posedge clk) disable iff (!rstN)
    chipFail[0] |-> (memAEn && memAWe && !memBEn && !reqReady &&
                     memAWdata == memBRdata && memAAddr == $past(memAAddr)));

  assert_repair_chip_b_R5: assert property (@(posedge clk) disable iff (!rstN)
    chipFail[1] |-> (memBEn && memBWe && !memAEn && !reqReady &&
                     memBWdata == memARdata && memBAddr == $past(memBAddr)));

  assert_single_stall_R5: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> reqReady);

  assert_lost_no_writeback_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (reqReady && chipFail == 2'b00));

  assert_corr_hold_top_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!cntClear && corrCount == CNT_TOP) |=> corrCount == CNT_TOP);

  assert_lost_hold_top_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!cntClear && uncorrCount == CNT_TOP) |=> uncorrCount == CNT_TOP);

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    cntClear |=> (corrCount == '0 && uncorrCount == '0 && faultLatched == 2'b00));

  assert_fault_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (chipFail[0] && !cntClear) |=> faultLatched[0]);

  assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (faultLatched[1] && !cntClear) |=> faultLatched[1]);

endmodule

bind mirror_mem_ctrl mirror_mem_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_checker (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqWrite     (reqWrite),
  .reqReady     (reqReady),
  .rspValid     (rspValid),
  .rspErr       (rspErr),
  .chipFail     (chipFail),
  .memAEn       (memAEn),
  .memAWe       (memAWe),
  .memAAddr     (memAAddr),
  .memAWdata    (memAWdata),
  .memARdata    (memARdata),
  .memBEn       (memBEn),
  .memBWe       (memBWe),
  .memBAddr     (memBAddr),
  .memBWdata    (memBWdata),
  .memBRdata    (memBRdata),
  .faultLatched (faultLatched),
  .corrCount    (corrCount),
  .uncorrCount  (uncorrCount),
  .cntClear     (cntClear)
);

// File: tb/mirror_mem_ctrl_bench.sv
`timescale 1ns/1ps
module mirror_mem_ctrl_bench;

  localparam int AW    = 4;
  localparam int DW    = 32;
  localparam int CW    = 3;
  localparam int WW    = DW + 4;
  localparam int WDOG  = 50000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          cntClear = 1'b0;
  logic          reqReady, rspValid, rspErr;
  logic [DW-1:0] rspData;
  logic          memAEn, memAWe, memBEn, memBWe;
  logic [AW-1:0] memAAddr, memBAddr;
  logic [WW-1:0] memAWdata, memBWdata;
  logic [WW-1:0] ramARd = '0;
  logic [WW-1:0] ramBRd = '0;
  logic [1:0]    chipFail, faultLatched;
  logic [CW-1:0] corrCount, uncorrCount;

  logic [WW-1:0] ramA [16] = '{default: '0};
  logic [WW-1:0] ramB [16] = '{default: '0};
  logic          injEn = 1'b0;
  logic          injB = 1'b0;
  logic [AW-1:0] injAddr = '0;
  logic [WW-1:0] injMask = '0;

  int stimChecks = 0, stimFails = 0;
  int modChecks = 0, modFails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  mirror_mem_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u_mirror_mem_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr),
    .memAEn(memAEn), .memAWe(memAWe), .memAAddr(memAAddr), .memAWdata(memAWdata),
    .memARdata(ramARd),
    .memBEn(memBEn), .memBWe(memBWe), .memBAddr(memBAddr), .memBWdata(memBWdata),
    .memBRdata(ramBRd),
    .chipFail(chipFail), .faultLatched(faultLatched),
    .corrCount(corrCount), .uncorrCount(uncorrCount), .cntClear(cntClear)
  );

  // Two synchronous SRAM chips with one-cycle read latency, plus bit-flip injection
  always @(posedge clk) begin
    if (injEn) begin
      if (injB) ramB[injAddr] <= ramB[injAddr] ^ injMask;
      else      ramA[injAddr] <= ramA[injAddr] ^ injMask;
    end
    if (memAEn) begin
      if (memAWe) ramA[memAAddr] <= memAWdata;
      else        ramARd <= ramA[memAAddr];
    end
    if (memBEn) begin
      if (memBWe) ramB[memBAddr] <= memBWdata;
      else        ramBRd <= ramB[memBAddr];
    end
  end

  // CRC-4, generator x^4+x+1, zero start, data MSB first
  function automatic logic [3:0] refCrc(input logic [31:0] d);
    logic [3:0] r = 4'h0;
    for (int i = 31; i >= 0; i--) begin
      if (r[3] != d[i]) r = {r[2:0], 1'b0} ^ 4'b0011;
      else              r = {r[2:0], 1'b0};
    end
    return r;
  endfunction

  // 0 identical, 1 chip A at fault, 2 chip B at fault, 3 undecidable
  function automatic int judge(input logic [35:0] a, input logic [35:0] b);
    bit okA, okB;
    if (a == b) return 0;
    okA = (refCrc(a[31:0]) == a[35:32]);
    okB = (refCrc(b[31:0]) == b[35:32]);
    if (!okA && okB) return 1;
    if (okA && !okB) return 2;
    return 3;
  endfunction

  // ---------------- per-cycle reference model ----------------
  bit            expPend = 1'b0;
  logic [CW-1:0] expCorr = '0;
  logic [CW-1:0] expLost = '0;
  logic [1:0]    expFault = '0;

  task automatic mchk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
    modChecks++;
    if (!ok) begin
      modFails++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int v;
    bit eReady;
    logic [31:0] eData;
    cycles++;
    if (cycles > WDOG) begin
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("[TB] %0d tests run, %0d failed",
               stimChecks + modChecks + 1, stimFails + modFails + 1);
      $finish;
    end
    if (!rstN) begin
      expPend = 1'b0; expCorr = '0; expLost = '0; expFault = '0;
    end else begin
      v = expPend ? judge(ramARd, ramBRd) : 0;
      eReady = !(v == 1 || v == 2);
      mchk(reqReady == eReady, "R5", "reqReady", 64'(reqReady), 64'(eReady));
      mchk(rspValid == expPend, "R3", "rspValid", 64'(rspValid), 64'(expPend));
      if (expPend) begin
        eData = (v == 1) ? ramBRd[31:0] : ramARd[31:0];
        mchk(rspData == eData, (v == 0) ? "R3" : ((v == 3) ? "R6" : "R4"),
             "rspData", 64'(rspData), 64'(eData));
      end
      mchk(rspErr == (v == 3), "R6", "rspErr", 64'(rspErr), 64'(v == 3));
      mchk(chipFail == {v == 2, v == 1}, "R4", "chipFail", 64'(chipFail),
           64'({v == 2, v == 1}));
      mchk(corrCount == expCorr, "R7", "corrCount", 64'(corrCount), 64'(expCorr));
      mchk(uncorrCount == expLost, "R7", "uncorrCount", 64'(uncorrCount), 64'(expLost));
      mchk(faultLatched == expFault, "R9", "faultLatched", 64'(faultLatched), 64'(expFault));
      if (cntClear) begin
        expCorr = '0; expLost = '0; expFault = '0;
      end else begin
        if ((v == 1 || v == 2) && expCorr != '1) expCorr = expCorr + 1'b1;
        if (v == 3 && expLost != '1) expLost = expLost + 1'b1;
        expFault = expFault | {v == 2, v == 1};
      end
      expPend = reqValid && eReady && !reqWrite;
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic schk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
    stimChecks++;
    if (!ok) begin
      stimFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic startReq(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
  endtask

  // returns at 1 ns after the accepting edge; waits = cycles held off
  task automatic waitAccept(output int waits);
    bit acc;
    waits = 0;
    do begin
      @(negedge clk);
      acc = reqReady;
      if (!acc) waits++;
      @(posedge clk);
      #1;
    end while (!acc);
  endtask

  task automatic writeWord(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int w;
    @(posedge clk); #1;
    startReq(1'b1, a, d);
    waitAccept(w);
    reqValid = 1'b0;
  endtask

  task automatic readCheck(input logic [AW-1:0] a, input logic [DW-1:0] expData,
                           input bit expErr, input string req);
    int w;
    @(posedge clk); #1;
    startReq(1'b0, a, '0);
    waitAccept(w);
    reqValid = 1'b0;
    @(negedge clk);
    schk(rspValid == 1'b1, req, "response present", 64'(rspValid), 64'(1));
    schk(rspData == expData, req, "read data", 64'(rspData), 64'(expData));
    schk(rspErr == expErr, req, "uncorrectable flag", 64'(rspErr), 64'(expErr));
  endtask

  task automatic inject(input bit toB, input logic [AW-1:0] a, input logic [WW-1:0] m);
    @(posedge clk); #1;
    injB = toB; injAddr = a; injMask = m; injEn = 1'b1;
    @(posedge clk); #1;
    injEn = 1'b0;
  endtask

  localparam logic [31:0] PAT0 = 32'h0000_0000;
  localparam logic [31:0] PAT1 = 32'hFFFF_FFFF;
  localparam logic [31:0] PAT2 = 32'hA5A5_5A5A;
  localparam logic [31:0] PAT3 = 32'h1234_5678;
  localparam logic [31:0] PAT4 = 32'hCAFE_0001;

  initial begin
    int w;
    logic [31:0] m;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    @(negedge clk);
    schk(reqReady == 1'b1, "R10", "ready after reset", 64'(reqReady), 64'(1));
    schk(rspValid == 1'b0, "R10", "no response after reset", 64'(rspValid), 64'(0));
    schk(corrCount == '0 && uncorrCount == '0, "R10", "counts after reset",
         64'({corrCount, uncorrCount}), 64'(0));
    schk(faultLatched == 2'b00, "R10", "fault bits after reset", 64'(faultLatched), 64'(0));

    // R1 R2: writes land identically in both chips with the checksum on top
    writeWord(0, PAT0);
    writeWord(1, PAT1);
    writeWord(2, PAT2);
    writeWord(3, PAT3);
    writeWord(4, PAT4);
    @(posedge clk); #1;
    schk(ramA[3] == {refCrc(PAT3), PAT3}, "R2", "chip A stored word", 64'(ramA[3]),
         64'({refCrc(PAT3), PAT3}));
    schk(ramB[3] == ramA[3], "R1", "chips mirror", 64'(ramB[3]), 64'(ramA[3]));
    schk(ramA[1] == {refCrc(PAT1), PAT1}, "R2", "chip A stored word", 64'(ramA[1]),
         64'({refCrc(PAT1), PAT1}));

    // R3: clean reads, then back-to-back without stalls
    readCheck(2, PAT2, 1'b0, "R3");
    readCheck(3, PAT3, 1'b0, "R3");
    @(posedge clk); #1;
    startReq(1'b0, 0, '0); waitAccept(w);
    startReq(1'b0, 1, '0); waitAccept(w);
    schk(w == 0, "R3", "back-to-back stall cycles", 64'(w), 64'(0));
    startReq(1'b0, 2, '0); waitAccept(w);
    reqValid = 1'b0;

    // R4 R5: data bit flipped in chip B
    inject(1'b1, 1, 36'h0_0000_0080);
    readCheck(1, PAT1, 1'b0, "R4");
    @(posedge clk); #1;
    schk(ramB[1] == ramA[1], "R5", "chip B repaired", 64'(ramB[1]), 64'(ramA[1]));

    // R4 R5: checksum bit flipped in chip A
    inject(1'b0, 2, 36'h2_0000_0000);
    readCheck(2, PAT2, 1'b0, "R4");
    @(posedge clk); #1;
    schk(ramA[2] == {refCrc(PAT2), PAT2}, "R5", "chip A repaired", 64'(ramA[2]),
         64'({refCrc(PAT2), PAT2}));
    schk(faultLatched == 2'b11, "R9", "both chips blamed", 64'(faultLatched), 64'(3));

    // R5: a read queued behind a repair waits exactly one cycle
    inject(1'b1, 0, 36'h0_0001_0000);
    @(posedge clk); #1;
    startReq(1'b0, 0, '0); waitAccept(w);
    startReq(1'b0, 3, '0); waitAccept(w);
    reqValid = 1'b0;
    schk(w == 1, "R5", "stall cycles behind repair", 64'(w), 64'(1));

    // R6: both copies fail their checksums
    inject(1'b0, 3, 36'h0_0000_0001);
    inject(1'b1, 3, 36'h0_0000_0002);
    readCheck(3, PAT3 ^ 32'h1, 1'b1, "R6");
    @(posedge clk); #1;
    schk(ramB[3] == {refCrc(PAT3), PAT3 ^ 32'h2}, "R6", "no write-back", 64'(ramB[3]),
         64'({refCrc(PAT3), PAT3 ^ 32'h2}));

    // R6: both copies valid but different; chip A's data is returned
    m = 32'h0000_0100;
    inject(1'b1, 4, {refCrc(m), m});
    readCheck(4, PAT4, 1'b1, "R6");
    @(posedge clk); #1;
    schk(ramB[4] == {refCrc(PAT4 ^ m), PAT4 ^ m}, "R6", "valid copy untouched",
         64'(ramB[4]), 64'({refCrc(PAT4 ^ m), PAT4 ^ m}));

    // R7: drive the uncorrectable count past its top
    for (int i = 0; i < 8; i++) readCheck(3, PAT3 ^ 32'h1, 1'b1, "R6");
    @(negedge clk);
    schk(uncorrCount == 3'd7, "R7", "uncorrectable count holds at top", 64'(uncorrCount), 64'(7));

    // R7: drive the corrected count past its top
    for (int i = 0; i < 6; i++) begin
      inject(1'b1, 1, 36'h0_0000_0001 << i);
      readCheck(1, PAT1, 1'b0, "R4");
    end
    @(negedge clk);
    schk(corrCount == 3'd7, "R7", "corrected count holds at top", 64'(corrCount), 64'(7));
    repeat (4) @(posedge clk);
    #1;
    schk(faultLatched == 2'b11, "R9", "fault bits held while idle", 64'(faultLatched), 64'(3));

    // R8: clear in the same cycle as a correction
    inject(1'b0, 0, 36'h0_0000_0020);
    @(posedge clk); #1;
    startReq(1'b0, 0, '0); waitAccept(w);
    reqValid = 1'b0;
    cntClear = 1'b1;
    @(posedge clk); #1;
    cntClear = 1'b0;
    schk(corrCount == '0, "R8", "corrected count after clear", 64'(corrCount), 64'(0));
    schk(uncorrCount == '0, "R8", "uncorrectable count after clear", 64'(uncorrCount), 64'(0));
    schk(faultLatched == 2'b00, "R8", "fault bits after clear", 64'(faultLatched), 64'(0));

    // Rewrite the damaged word; it reads back clean (R3)
    writeWord(3, PAT3);
    readCheck(3, PAT3, 1'b0, "R3");
    @(negedge clk);
    schk(corrCount == '0 && uncorrCount == '0, "R3", "clean read leaves counts",
         64'({corrCount, uncorrCount}), 64'(0));

    repeat (3) @(posedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", stimChecks + modChecks, stimFails + modFails);
    $finish;
  end

endmodule